// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns each 16-bit CPU address into exactly one region select: the internal control-register block, internal RAM, the EEPROM array, the ROM array, or the external bus. ROM and EEPROM sit at fixed, parameterized ranges. RAM and the 64-byte register block can each be moved to the start of any 4-Kbyte page. Their positions come from an 8-bit placement register that lives inside the register block itself.

In the normal operating modes, the placement register can be loaded only once. The load must also arrive within a short window of clock cycles after reset. In the two special modes the register stays writable at all times. Disabled ROM or EEPROM space is handed to the external bus. In single-chip mode the ROM is always internal.

The selects are purely combinational from the address and the current register contents. The register contents are always presented on a read-data output.

Top module: `relocmap_decoder`

## Requirements
- R1: After a synchronous reset the placement register reads 0x01. RAM then answers at 0x0000–0x01FF and the register block answers at 0x1000–0x103F.
- R2: Placement bits 7:4 give the RAM page and bits 3:0 give the register-block page. A region's base is page × 0x1000. RAM spans 512 bytes from its base and the register block spans 64 bytes from its base.
- R3: A write (wr_en high) to register-block offset 0x3D at the current mapping loads wdata into the placement register. map_rdata and the selects reflect the new value right after that clock edge.
- R4: In a normal mode (mode bit 1 = 0), only the first accepted write takes effect. Any later write is ignored.
- R5: In a normal mode, a write is accepted only on clock edges 0 through 63 after reset release. A write on edge 64 or later is ignored.
- R6: In a special mode (mode 10 = bootstrap, 11 = test), every write to the placement register is accepted, at any time.
- R7: ROM space (0xD000–0xFFFF) selects ROM when rom_en is 1 or mode is 00 (single-chip). When rom_en is 0 and mode is not 00, ROM space selects the external bus. Mode 01 is expanded.
- R8: EEPROM space (0xB600–0xB7FF) selects EEPROM when eep_en is 1. Otherwise it selects the external bus.
- R9: Overlapping regions resolve in this order: register block, then RAM, then EEPROM, then ROM. Any address that matches no internal region selects the external bus.
- R10: Exactly one of the five selects is active at every address.
- R11: A write to any address other than the placement register's location leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one bus cycle per edge) |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data |
| mode | input | 2 | 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| rom_en | input | 1 | ROM enable configuration bit |
| eep_en | input | 1 | EEPROM enable configuration bit |
| sel_reg | output | 1 | Register block selected |
| sel_ram | output | 1 | Internal RAM selected |
| sel_eep | output | 1 | EEPROM selected |
| sel_rom | output | 1 | ROM selected |
| sel_ext | output | 1 | External bus selected |
| map_rdata | output | 8 | Current placement register contents |

## Verification
The selects depend on the address in the same cycle, with no register in the path. The bench therefore drives an address just after a rising edge and compares the selects at the following falling edge.

A placement write is registered on the edge that ends the write cycle. Its effect on map_rdata and on the selects is due one edge after the strobe was driven, and every probe that follows a write is issued after that edge.

The window boundary is hit exactly by counting rising edges since reset release in the bench. Writes are then aimed at edge 63, which must be accepted, and at edge 64, which must be rejected.

// File: rtl/mapdec_pkg.sv
// Package: shared constants for the relocatable map decoder.
// Region indices set the priority order; a lower index wins.
package mapdec_pkg;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned MAP_W    = 8;
    localparam int unsigned FIELD_W  = 4;
    localparam int unsigned N_INT    = 4;

    typedef enum int unsigned {
        IDX_REG = 0,
        IDX_RAM = 1,
        IDX_EEP = 2,
        IDX_ROM = 3
    } region_idx_e;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'b00,
        MODE_EXPAND  = 2'b01,
        MODE_BOOT    = 2'b10,
        MODE_TEST    = 2'b11
    } op_mode_e;
endpackage

// File: rtl/mapdec_hit.sv
// Module: mapdec_hit
// Flags an address inside [base, base+SIZE-1].
// Assumes the window does not wrap past the top of the address space.
module mapdec_hit #(
    parameter int unsigned AW   = 16,
    parameter int unsigned SIZE = 512
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW:0] SPAN = (AW+1)'(SIZE - 1);

    logic [AW:0] lo_b;
    logic [AW:0] hi_b;
    logic [AW:0] a_x;

    // Range compare carried one bit wider so the upper bound cannot overflow.
    always_comb begin
        lo_b = {1'b0, base};
        hi_b = lo_b + SPAN;
        a_x  = {1'b0, addr};
        hit  = (a_x >= lo_b) && (a_x <= hi_b);
    end
endmodule

// File: rtl/mapdec_prio.sv
// Module: mapdec_prio
// Fixed-priority one-hot picker: bit 0 wins. When no bit is set, the
// fall-through output is raised instead.
module mapdec_prio #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] hit,
    output logic [N-1:0] pick,
    output logic         none
);
    // Walk from highest priority down; the first set bit claims the access.
    always_comb begin
        logic taken;
        taken = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !taken) begin
                pick[i] = 1'b1;
                taken   = 1'b1;
            end
        end
        none = !taken;
    end
endmodule

// File: rtl/mapdec_mapreg.sv
// Module: mapdec_mapreg
// Holds the placement register. In normal modes a write is accepted
// only while the post-reset cycle counter is below WINDOW, and only once.
// In special modes every write is accepted. Assumes wr_hit is already
// qualified by the address decode.
module mapdec_mapreg #(
    parameter int unsigned   W         = 8,
    parameter int unsigned   WINDOW    = 64,
    parameter logic [W-1:0]  RESET_VAL = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         special,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] map_q
);
    localparam int unsigned CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] CLOSE = CW'(WINDOW);

    logic [CW-1:0] cnt;
    logic          done;
    logic          open_n;
    logic          accept;

    // Window is open while the counter is short of the limit.
    always_comb begin
        open_n = (cnt == CLOSE);
        accept = wr_hit && (special || (!open_n && !done));
    end

    // Saturating count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!open_n) cnt <= cnt + 1'b1;
    end

    // Placement register and its once-written marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= RESET_VAL;
            done  <= 1'b0;
        end else if (accept) begin
            map_q <= wdata;
            done  <= 1'b1;
        end
    end

    p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (map_q == RESET_VAL));

    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CLOSE);

    p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!special && (done || cnt == CLOSE)) |=> $stable(map_q));

    p_special_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (special && wr_hit) |=> (map_q == $past(wdata)));
endmodule

// File: rtl/relocmap_decoder.sv
// Module: relocmap_decoder (top)
// Decodes a CPU address into one of five region selects. RAM and the
// register block follow the placement register; ROM and EEPROM sit at
// fixed ranges and fall to the external bus when disabled. Assumes the
// relocatable regions fit inside one 4-Kbyte page.
module relocmap_decoder
    import mapdec_pkg::*;
#(
    parameter int unsigned        REG_SIZE  = 64,
    parameter int unsigned        RAM_SIZE  = 512,
    parameter logic [ADDR_W-1:0]  EEP_BASE  = 16'hB600,
    parameter int unsigned        EEP_SIZE  = 512,
    parameter logic [ADDR_W-1:0]  ROM_BASE  = 16'hD000,
    parameter int unsigned        ROM_SIZE  = 12288,
    parameter int unsigned        MAP_OFS   = 'h3D,
    parameter int unsigned        WINDOW    = 64,
    parameter logic [MAP_W-1:0]   MAP_RESET = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [MAP_W-1:0]  wdata,
    input  logic [1:0]        mode,
    input  logic              rom_en,
    input  logic              eep_en,
    output logic              sel_reg,
    output logic              sel_ram,
    output logic              sel_eep,
    output logic              sel_rom,
    output logic              sel_ext,
    output logic [MAP_W-1:0]  map_rdata
);
    localparam int unsigned REG_AW  = $clog2(REG_SIZE);
    localparam int unsigned LOW_W   = ADDR_W - FIELD_W;

    logic [MAP_W-1:0]  map_q;
    logic [ADDR_W-1:0] reg_base;
    logic [ADDR_W-1:0] ram_base;
    logic              reg_hit, ram_hit, eep_hit, rom_hit;
    logic              rom_on, special, map_wr;
    logic [N_INT-1:0]  hits;
    logic [N_INT-1:0]  pick;
    logic              none;

    // Page bases from the two placement fields.
    always_comb begin
        ram_base = {map_q[MAP_W-1 -: FIELD_W], {LOW_W{1'b0}}};
        reg_base = {map_q[FIELD_W-1:0],        {LOW_W{1'b0}}};
    end

    mapdec_hit #(.AW(ADDR_W), .SIZE(REG_SIZE)) u_hit_reg (
        .base(reg_base), .addr(addr), .hit(reg_hit));
    mapdec_hit #(.AW(ADDR_W), .SIZE(RAM_SIZE)) u_hit_ram (
        .base(ram_base), .addr(addr), .hit(ram_hit));
    mapdec_hit #(.AW(ADDR_W), .SIZE(EEP_SIZE)) u_hit_eep (
        .base(EEP_BASE), .addr(addr), .hit(eep_hit));
    mapdec_hit #(.AW(ADDR_W), .SIZE(ROM_SIZE)) u_hit_rom (
        .base(ROM_BASE), .addr(addr), .hit(rom_hit));

    // Mode qualifiers and the placement-register write strobe.
    always_comb begin
        special = mode[1];
        rom_on  = rom_en || (op_mode_e'(mode) == MODE_SINGLE);
        map_wr  = wr_en && reg_hit && (addr[REG_AW-1:0] == REG_AW'(MAP_OFS));
    end

    // Qualified hits in priority order.
    always_comb begin
        hits          = '0;
        hits[IDX_REG] = reg_hit;
        hits[IDX_RAM] = ram_hit;
        hits[IDX_EEP] = eep_hit && eep_en;
        hits[IDX_ROM] = rom_hit && rom_on;
    end

    mapdec_prio #(.N(N_INT)) u_prio (
        .hit(hits), .pick(pick), .none(none));

    mapdec_mapreg #(.W(MAP_W), .WINDOW(WINDOW), .RESET_VAL(MAP_RESET)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_hit(map_wr), .special(special),
        .wdata(wdata), .map_q(map_q));

    // Drive the output selects and read data.
    always_comb begin
        sel_reg   = pick[IDX_REG];
        sel_ram   = pick[IDX_RAM];
        sel_eep   = pick[IDX_EEP];
        sel_rom   = pick[IDX_ROM];
        sel_ext   = none;
        map_rdata = map_q;
    end

    p_one_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_reg, sel_ram, sel_eep, sel_rom, sel_ext}) == 1);

    p_reg_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |-> sel_reg);

    p_eep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !eep_en |-> !sel_eep);

    p_rom_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && rom_hit && !reg_hit && !ram_hit) |-> sel_rom);
endmodule

// File: tb/relocmap_decoder_test.sv
`timescale 1ns/1ps
module relocmap_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [1:0]  mode = 2'b01;
    logic        rom_en = 1'b1;
    logic        eep_en = 1'b1;
    logic        sel_reg, sel_ram, sel_eep, sel_rom, sel_ext;
    logic [7:0]  map_rdata;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    logic [7:0] mdl_map = 8'h01;
    bit done_flag = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic [4:0]  sel;
        logic [7:0]  map;
        string       tag;
    } item_t;
    item_t sb[$];

    relocmap_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .mode(mode), .rom_en(rom_en), .eep_en(eep_en),
        .sel_reg(sel_reg), .sel_ram(sel_ram), .sel_eep(sel_eep),
        .sel_rom(sel_rom), .sel_ext(sel_ext), .map_rdata(map_rdata));

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Expected selects {ext, rom, eep, ram, reg} from the requirements.
    function automatic logic [4:0] model(input logic [15:0] a, input logic [7:0] m,
                                         input logic [1:0] md, input logic re,
                                         input logic ee);
        int rb, mb, ai;
        rb = int'(m[3:0]) * 4096;
        mb = int'(m[7:4]) * 4096;
        ai = int'(a);
        if (ai >= rb && ai < rb + 64)          return 5'b00001;
        if (ai >= mb && ai < mb + 512)         return 5'b00010;
        if (ee && ai >= 'hB600 && ai < 'hB800) return 5'b00100;
        if ((re || md == 2'b00) && ai >= 'hD000) return 5'b01000;
        return 5'b10000;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic do_reset(input logic [1:0] md);
        @(posedge clk); #1;
        rst_n = 1'b0; mode = md; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mdl_map = 8'h01;
    endtask

    // Write aimed at rising edge n after reset release (or the next one if later).
    task automatic wr(input int n, input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        while (cyc < n) begin @(posedge clk); #1; end
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Driver: apply an address and queue the expected outcome.
    task automatic probe(input logic [15:0] a, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.a = a; it.map = mdl_map; it.tag = tag;
        it.sel = model(a, mdl_map, mode, rom_en, eep_en);
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    // Monitor: compare at the falling edge after the address is applied.
    initial begin
        forever begin
            item_t it;
            logic [4:0] got;
            wait (sb.size() > 0);
            @(negedge clk);
            it = sb.pop_front();
            got = {sel_ext, sel_rom, sel_eep, sel_ram, sel_reg};
            compared++;
            if (got !== it.sel || map_rdata !== it.map) begin
                mismatched++;
                $display("FAIL %s addr=%h sel got=%b exp=%b map got=%h exp=%h",
                         it.tag, it.a, got, it.sel, map_rdata, it.map);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        // R1 / R2: reset mapping in expanded mode
        do_reset(2'b01);
        probe(16'h0000, "R1 ram low");
        probe(16'h01FF, "R2 ram top");
        probe(16'h0200, "R2 past ram");
        probe(16'h1000, "R1 reg low");
        probe(16'h103F, "R2 reg top");
        probe(16'h1040, "R2 past reg");
        // R3: first write relocates
        wr(0, 16'h103D, 8'h23); mdl_map = 8'h23;
        probe(16'h2000, "R3 ram moved");
        probe(16'h3010, "R3 reg moved");
        probe(16'h1000, "R3 old reg gone");
        // R4: second write ignored
        wr(0, 16'h303D, 8'h45);
        probe(16'h303D, "R4 second write ignored");
        // R11: other offset, then R5 late write at edge 64
        do_reset(2'b01);
        wr(0, 16'h103E, 8'h99);
        probe(16'h103E, "R11 other offset");
        wr(64, 16'h103D, 8'h55);
        probe(16'h0000, "R5 edge 64 rejected");
        // R5: write on edge 63 accepted
        do_reset(2'b01);
        wr(63, 16'h103D, 8'h67); mdl_map = 8'h67;
        probe(16'h703D, "R5 edge 63 accepted");
        probe(16'h6000, "R5 ram at new page");
        // R6 / R9: special mode rewrites and overlap priority
        do_reset(2'b11);
        wr(0, 16'h103D, 8'h11); mdl_map = 8'h11;
        probe(16'h1000, "R9 reg over ram");
        probe(16'h1040, "R9 ram after reg");
        wr(100, 16'h103D, 8'h22); mdl_map = 8'h22;
        probe(16'h2020, "R6 late rewrite");
        wr(120, 16'h203D, 8'h0F); mdl_map = 8'h0F;
        probe(16'hF000, "R9 reg over rom");
        probe(16'hF040, "R9 rom after reg");
        probe(16'hD000, "R7 rom enabled");
        // R7: rom disabled outside single-chip
        rom_en = 1'b0;
        probe(16'hD000, "R7 rom off to ext");
        // R8: eeprom enable
        probe(16'hB600, "R8 eep low");
        probe(16'hB7FF, "R8 eep top");
        probe(16'hB800, "R8 past eep");
        eep_en = 1'b0;
        probe(16'hB600, "R8 eep off to ext");
        // R7: single-chip forces rom
        mode = 2'b00;
        probe(16'hD000, "R7 single-chip rom");
        probe(16'h8000, "R10 unmapped ext");
        done_flag = 1'b1;
        summary();
    end
endmodule